// File: doc/BRIEF.md
# Shared Interrupt Flag Unit

This unit holds the eight interrupt flags that a group of four programmable I/O state machines share. Each cycle, every machine may present the opcode and the low operand byte of the instruction it is executing. The unit acts on two kinds of instruction. The first kind sets or clears one flag, and a set may also wait until the flag is cleared again. The second kind waits on a flag, either until it is set or until it is clear. For each machine the unit returns a stall bit, and the machine must present the same instruction again in any cycle where that bit is high.

A flag index can be absolute or relative to the machine's number. A relative index adds the machine number to the two low bits of the index, modulo four. Bit 2 of the index passes through unchanged. A host can clear flags by writing ones to a clear port. Flags 0 to 3, together with each machine's TX-not-full and RX-not-empty status, feed two interrupt lines. Each line has its own enable mask. The lines carry no record of which machine raised a flag.

Top module: `irq_flag_hub`

## Requirements
- R1: After reset all flags are 0, both interrupt lines are low and no machine is stalled.
- R2: Opcode 3'b110 (set/clear form) acts on flag operand[2:0] from the next clock edge. Operand bit 6 = 0 sets the flag and bit 6 = 1 clears it.
- R3: When operand bit 4 is 1, the target flag is {idx[2], (idx[1:0] + machine number) mod 4}. This holds for both the set/clear form and the wait form.
- R4: If one machine sets a flag and another clears it in the same cycle, the flag ends up set.
- R5: A set with operand bit 5 = 1 stalls the requester in the issuing cycle. The stall stays high while the flag is set and drops in the first cycle the flag reads 0. The flag is not set a second time while the requester waits.
- R6: Opcode 3'b001 with operand[6:5] = 2'b10 waits on a flag. It stalls while the flag differs from the polarity in operand bit 7. When polarity 1 is satisfied, the flag is cleared at the next edge. When polarity 0 is satisfied, the flag is left unchanged.
- R7: Two machines waiting with polarity 1 on the same flag are released in the same cycle, and the flag is cleared once.
- R8: A host write with the clear strobe high clears every flag whose data bit is 1 at the next edge. A set of the same flag in the same cycle wins.
- R9: Interrupt line k is the OR of (source AND enable mask k). The source vector has flags 0–3 in bits 3:0, TX-not-full per machine in bits 7:4 and RX-not-empty per machine in bits 11:8. Flags 4–7 never reach a line.
- R10: The unit ignores any other opcode, a wait-form instruction whose source field is not 2'b10, and any instruction with operand bit 3 set. Such instructions change no flag and cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sm_issue | input | NSM | Machine presents an instruction this cycle |
| sm_opcode | input | NSM×3 | Opcode field of each machine's instruction |
| sm_operand | input | NSM×8 | Low operand byte of each machine's instruction |
| sm_stall | output | NSM | Machine must hold and re-present its instruction |
| tx_not_full | input | NSM | Per-machine TX FIFO not full |
| rx_not_empty | input | NSM | Per-machine RX FIFO not empty |
| host_clr_we | input | 1 | Host clear strobe |
| host_clr_bits | input | 8 | Flags to clear, one bit per flag |
| line_en | input | 2×(4+2·NSM) | Enable mask for each interrupt line |
| flags | output | 8 | Current flag state |
| irq_line | output | 2 | Interrupt lines |

## Verification
A flag left wrong shows on the flags port one edge after the request that caused it. It also shows on the interrupt lines in that same cycle whenever the flag is one of the low four and is enabled. The pending-wait bit of each machine is the only state that cannot be seen directly. When it is wrong, the stall output shows the error in the first cycle a set-and-wait stays held. The stall either drops while the flag is still set, or the flag is set a second time after the host clears it. The directed scenarios therefore sample stall in every cycle of a held set-and-wait and of a held wait.

// File: rtl/irq_flag_hub.sv
module irq_flag_hub #(
  parameter int NSM = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSM-1:0]               sm_issue,
  input  logic [NSM-1:0][2:0]          sm_opcode,
  input  logic [NSM-1:0][7:0]          sm_operand,
  output logic [NSM-1:0]               sm_stall,
  input  logic [NSM-1:0]               tx_not_full,
  input  logic [NSM-1:0]               rx_not_empty,
  input  logic                         host_clr_we,
  input  logic [7:0]                   host_clr_bits,
  input  logic [1:0][4+2*NSM-1:0]      line_en,
  output logic [7:0]                   flags,
  output logic [1:0]                   irq_line
);
  localparam int NFLAG = 8;
  localparam int SRCW  = 4 + 2*NSM;

  logic [NSM-1:0]            pend;
  logic [NSM-1:0]            pend_nxt;
  logic [NSM-1:0][NFLAG-1:0] set_v;
  logic [NSM-1:0][NFLAG-1:0] clr_v;
  logic [NFLAG-1:0]          set_all;
  logic [NFLAG-1:0]          clr_all;
  logic [SRCW-1:0]           src;

  for (genvar g = 0; g < NSM; g++) begin : g_sm
    logic [7:0] op;
    logic [2:0] tgt;
    logic       is_irq, is_wait, is_set, hold, hit;
    assign op      = sm_operand[g];
    assign tgt     = op[4] ? {op[2], 2'(op[1:0] + 2'(g))} : op[2:0];
    assign is_irq  = sm_issue[g] && sm_opcode[g] == 3'b110 && !op[3];
    assign is_wait = sm_issue[g] && sm_opcode[g] == 3'b001 && op[6:5] == 2'b10 && !op[3];
    assign is_set  = is_irq && !op[6];
    assign hold    = is_set && op[5] && (!pend[g] || flags[tgt]);
    assign hit     = is_wait && (flags[tgt] == op[7]);
    assign sm_stall[g] = hold || (is_wait && !hit);
    assign pend_nxt[g] = hold;
    assign set_v[g] = (is_set && !(op[5] && pend[g])) ? NFLAG'(1) << tgt : '0;
    assign clr_v[g] = ((is_irq && op[6]) || (hit && op[7])) ? NFLAG'(1) << tgt : '0;
  end

  always_comb begin
    set_all = '0;
    clr_all = host_clr_we ? host_clr_bits : '0;
    for (int i = 0; i < NSM; i++) begin
      set_all = set_all | set_v[i];
      clr_all = clr_all | clr_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      pend  <= '0;
    end else begin
      flags <= (flags & ~clr_all) | set_all;
      pend  <= pend_nxt;
    end
  end

  assign src = {rx_not_empty, tx_not_full, flags[3:0]};

  for (genvar k = 0; k < 2; k++) begin : g_line
    assign irq_line[k] = |(src & line_en[k]);
  end
endmodule

// File: rtl/irq_flag_hub_chk.sv
module irq_flag_hub_chk #(
  parameter int NSM = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSM-1:0]          sm_issue,
  input logic [NSM-1:0]          sm_stall,
  input logic                    host_clr_we,
  input logic [7:0]              host_clr_bits,
  input logic [1:0][4+2*NSM-1:0] line_en,
  input logic [7:0]              flags,
  input logic [1:0]              irq_line
);
  // R2
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags)) != 8'h0) |-> $past(|sm_issue));

  // R8
  flag_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags)) != 8'h0) |-> ($past(|sm_issue) || $past(host_clr_we)));

  // R8
  host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr_we && sm_issue == '0) |=> ((flags & $past(host_clr_bits)) == 8'h0));

  // R5
  stall_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_stall & ~sm_issue) == '0);

  // R9
  line0_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en[0] == '0) |-> !irq_line[0]);

  // R9
  line1_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en[1] == '0) |-> !irq_line[1]);
endmodule

bind irq_flag_hub irq_flag_hub_chk #(.NSM(NSM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sm_issue(sm_issue), .sm_stall(sm_stall),
  .host_clr_we(host_clr_we), .host_clr_bits(host_clr_bits),
  .line_en(line_en), .flags(flags), .irq_line(irq_line)
);

// File: tb/test_irq_flag_hub.sv
`timescale 1ns/1ps
module test_irq_flag_hub;
  localparam int NSM = 4;
  logic clk = 0, rst_n = 0;
  logic [NSM-1:0] sm_issue = '0;
  logic [NSM-1:0][2:0] sm_opcode = '0;
  logic [NSM-1:0][7:0] sm_operand = '0;
  logic [NSM-1:0] sm_stall, tx_not_full = '0, rx_not_empty = '0;
  logic host_clr_we = 0;
  logic [7:0] host_clr_bits = '0;
  logic [1:0][11:0] line_en = '0;
  logic [7:0] flags;
  logic [1:0] irq_line;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  irq_flag_hub #(.NSM(NSM)) i_irq_flag_hub (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [2:0] opc, input logic [7:0] opr);
    sm_issue[i] = 1'b1; sm_opcode[i] = opc; sm_operand[i] = opr;
  endtask

  function automatic logic [7:0] irqf(input bit clr, input bit wt, input bit rel, input int idx);
    return {1'b0, clr, wt, rel, 1'b0, 3'(idx)};
  endfunction

  function automatic logic [7:0] waitf(input bit pol, input bit rel, input int idx);
    return {pol, 2'b10, rel, 1'b0, 3'(idx)};
  endfunction

  task automatic idle();
    sm_issue = '0; host_clr_we = 0; host_clr_bits = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wipe();
    idle(); host_clr_we = 1; host_clr_bits = 8'hFF; step(); idle();
  endtask

  task automatic t_reset();
    chk(flags, 8'h00, "R1 flags");
    chk(irq_line, 2'b00, "R1 lines");
    chk(sm_stall, 4'h0, "R1 stall");
  endtask

  task automatic t_set_clear();
    put(0, 3'b110, irqf(0,0,0,5)); step(); idle();
    chk(flags, 8'h20, "R2 set 5");
    put(1, 3'b110, irqf(1,0,0,5)); step(); idle();
    chk(flags, 8'h00, "R2 clear 5");
  endtask

  task automatic t_relative();
    put(2, 3'b110, irqf(0,0,1,3));
    put(3, 3'b110, irqf(0,0,1,6)); step(); idle();
    chk(flags, 8'h22, "R3 relative set");
    wipe();
  endtask

  task automatic t_collide();
    put(0, 3'b110, irqf(0,0,0,2));
    put(1, 3'b110, irqf(1,0,0,2)); step(); idle();
    chk(flags, 8'h04, "R4 set beats clear");
    put(1, 3'b110, irqf(0,0,0,2));
    host_clr_we = 1; host_clr_bits = 8'h04; step(); idle();
    chk(flags, 8'h04, "R8 set beats host clear");
    host_clr_we = 1; host_clr_bits = 8'h04; step(); idle();
    chk(flags, 8'h00, "R8 host clear");
  endtask

  task automatic t_setwait();
    put(1, 3'b110, irqf(0,1,0,3)); #1;
    chk(sm_stall[1], 1'b1, "R5 stall on issue");
    step();
    chk(flags, 8'h08, "R5 flag set");
    chk(sm_stall[1], 1'b1, "R5 stall while set");
    host_clr_we = 1; host_clr_bits = 8'h08; step();
    host_clr_we = 0; host_clr_bits = '0; #1;
    chk(flags, 8'h00, "R5 cleared by host");
    chk(sm_stall[1], 1'b0, "R5 released");
    step(); idle();
    chk(flags, 8'h00, "R5 no second set");
  endtask

  task automatic t_wait();
    put(0, 3'b001, waitf(1,0,6)); #1;
    chk(sm_stall[0], 1'b1, "R6 wait high stalls");
    put(3, 3'b110, irqf(0,0,0,6)); step();
    sm_issue[3] = 0; #1;
    chk(sm_stall[0], 1'b0, "R6 wait high satisfied");
    step(); idle();
    chk(flags, 8'h00, "R6 flag consumed");
    put(0, 3'b110, irqf(0,0,0,1)); step(); idle();
    put(1, 3'b001, waitf(0,1,0)); #1;
    chk(sm_stall[1], 1'b1, "R6 R3 wait low relative stalls");
    put(2, 3'b110, irqf(1,0,1,3)); step();
    sm_issue[2] = 0; #1;
    chk(sm_stall[1], 1'b0, "R6 wait low released");
    step(); idle();
    chk(flags, 8'h00, "R6 wait low leaves flag");
  endtask

  task automatic t_two_waiters();
    put(2, 3'b001, waitf(1,0,4));
    put(3, 3'b001, waitf(1,0,4)); #1;
    chk(sm_stall[3:2], 2'b11, "R7 both stall");
    put(0, 3'b110, irqf(0,0,0,4)); step();
    sm_issue[0] = 0; #1;
    chk(sm_stall[3:2], 2'b00, "R7 both released");
    step(); idle();
    chk(flags, 8'h00, "R7 flag cleared once");
  endtask

  task automatic t_lines();
    put(0, 3'b110, irqf(0,0,0,0));
    put(1, 3'b110, irqf(0,0,0,5)); step(); idle();
    line_en[0] = 12'h001; line_en[1] = 12'h020; tx_not_full = 4'b0010; #1;
    chk(irq_line, 2'b11, "R9 flag0 and txnf1");
    line_en[1] = '0; #1;
    chk(irq_line[1], 1'b0, "R9 mask off");
    line_en[0] = 12'h00F; host_clr_we = 1; host_clr_bits = 8'h01; step(); idle();
    chk(irq_line[0], 1'b0, "R9 high flags not routed");
    line_en[0] = 12'h100; rx_not_empty = 4'b0001; #1;
    chk(irq_line[0], 1'b1, "R9 rxne0");
    line_en = '0; tx_not_full = '0; rx_not_empty = '0;
    wipe();
  endtask

  task automatic t_other();
    put(0, 3'b111, 8'h03);
    put(1, 3'b001, 8'h83);
    put(2, 3'b110, 8'h0A); #1;
    chk(sm_stall, 4'h0, "R10 no stall");
    step(); idle();
    chk(flags, 8'h00, "R10 no flag change");
  endtask

  initial begin
    repeat (4) step();
    rst_n = 1; step();
    t_reset();
    t_set_clear();
    t_relative();
    t_collide();
    t_setwait();
    t_wait();
    t_two_waiters();
    t_lines();
    t_other();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule